// File: doc/BRIEF.md
# Real-Time Clock Alarm Timer

This block is a 32-bit slow-tick up-counter paired with a 32-bit alarm comparator. A single-cycle enable pulse from a low-rate timebase advances the counter, and software reaches the block through a small register port. Through that port software can load the counter, read it, set the alarm value, choose the mode and start or stop counting.

The block has two modes. In wrap mode the counter is never cleared: it rolls from all-ones to zero without stopping, and a sticky overflow flag records each roll so software can extend the timebase. Software adds the next interval to the alarm value with modulo-2^32 arithmetic after each alarm. In periodic mode the hardware clears the counter when the alarm value is reached, so the alarm repeats every alarm-value ticks and the alarm value is written only once. In both modes an alarm raises a sticky flag that drives the interrupt line until software clears it.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After synchronous reset the counter, the alarm value, the control bits and both status flags are zero, and `irq` is low.
- R2: The counter changes only on a cycle where `tick` is high and the run bit is set. On every other cycle it holds, unless software writes the timer in that cycle.
- R3: In wrap mode (control bit 1 = 0) the counter rolls from all-ones to zero and keeps counting. That advance sets the overflow flag (status bit 1).
- R4: In wrap mode an advance whose new count equals a non-zero alarm value sets the alarm flag (status bit 0). The counter takes the new count, and the match is plain equality, including just after a roll.
- R5: In periodic mode (control bit 1 = 1) with a non-zero alarm value A, an advance from A-1 loads zero instead of A and sets the alarm flag. The alarm period is therefore exactly A ticks, and the alarm register keeps its value.
- R6: An alarm value of zero disables alarm detection in both modes. In periodic mode the counter then rolls without setting either flag.
- R7: Status flags are sticky. Writing status with a bit at 1 clears that flag, and a 0 bit has no effect. A new event in the same cycle as a clear leaves the flag set. `irq` equals the alarm flag.
- R8: A timer write loads the written value and takes priority over counting and over the periodic clear in the same cycle. That cycle produces no alarm or overflow event.
- R9: Register map by `reg_addr`: 0 timer, 1 alarm, 2 control (bit 0 run, bit 1 mode), 3 status (bit 0 alarm, bit 1 overflow). The unused bits of control and status read as zero. `reg_rdata` follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timebase enable, one cycle per count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Alarm interrupt, level of the sticky alarm flag |

## Verification
The bench sweeps periodic mode over alarm values 1 to 6 for several periods each. An off-by-one clear would show up there as a period of A+1 ticks, or as the counter visibly passing through A. It loads the counter just below all-ones to check two things: the overflow flag on the roll, and an alarm value that lies past the roll. A magnitude compare or a missing wrap would then fire early or never. It also covers four further cases. An alarm value of zero must stay silent in both modes. A timer write that coincides with a tick, at a count one below the alarm, must win without firing. A status clear that lands on the same edge as a fresh alarm must not lose the alarm. Writing 0 to status must change nothing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    typedef enum logic [1:0] {
        ADDR_TIMER  = 2'd0,
        ADDR_ALARM  = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_STATUS = 2'd3
    } rtc_addr_e;

    typedef enum logic {
        MODE_WRAP     = 1'b0,
        MODE_PERIODIC = 1'b1
    } rtc_mode_e;

    typedef struct packed {
        rtc_mode_e mode;
        logic      run;
    } rtc_ctrl_t;

    typedef struct packed {
        logic ld_timer;
        logic ld_alarm;
        logic ld_ctrl;
        logic ld_status;
    } rtc_wsel_t;

    // Flag indices inside the status word.
    localparam int FLAG_ALARM = 0;
    localparam int FLAG_OVF   = 1;
    localparam int NUM_FLAGS  = 2;

    typedef struct packed {
        logic wrapped;
        logic hit;
    } rtc_evt_t;

    function automatic rtc_wsel_t decode_write(input logic wr, input rtc_addr_e a);
        rtc_wsel_t s;
        s.ld_timer  = wr && (a == ADDR_TIMER);
        s.ld_alarm  = wr && (a == ADDR_ALARM);
        s.ld_ctrl   = wr && (a == ADDR_CTRL);
        s.ld_status = wr && (a == ADDR_STATUS);
        return s;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rtc_wsel_t            wsel,
    input  logic [CNT_W-1:0]     wdata,
    input  rtc_addr_e            raddr,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [CNT_W-1:0]     alarm,
    output rtc_ctrl_t            ctrl,
    output logic [CNT_W-1:0]     rdata
);
    localparam int CTRL_W = $bits(rtc_ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= '0;
            ctrl  <= '{mode: MODE_WRAP, run: 1'b0};
        end else begin
            if (wsel.ld_alarm) alarm <= wdata;
            if (wsel.ld_ctrl)  ctrl  <= rtc_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        unique case (raddr)
            ADDR_TIMER:  rdata = cnt;
            ADDR_ALARM:  rdata = alarm;
            ADDR_CTRL:   rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
            ADDR_STATUS: rdata = {{(CNT_W-NUM_FLAGS){1'b0}}, flags};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] alarm,
    input  rtc_mode_e        mode,
    input  logic             adv,
    input  logic             load,
    output logic [CNT_W-1:0] nxt,
    output rtc_evt_t         evt,
    output logic             zero_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic armed;
    logic live;

    always_comb begin
        nxt          = cnt + ONE;
        armed        = (alarm != '0);
        live         = adv && !load;
        evt.hit      = live && armed && (nxt == alarm);
        evt.wrapped  = live && (mode == MODE_WRAP) && (nxt == '0);
        zero_req     = evt.hit && (mode == MODE_PERIODIC);
    end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             zero_req,
    input  logic             adv,
    input  logic [CNT_W-1:0] nxt,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (zero_req) cnt <= '0;
        else if (adv)      cnt <= nxt;
    end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);
    rtc_wsel_t            wsel;
    rtc_ctrl_t            ctrl;
    rtc_evt_t             evt;
    logic [CNT_W-1:0]     alarm;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cnt_nxt;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic                 adv;
    logic                 zero_req;

    assign wsel = decode_write(reg_wr, rtc_addr_e'(reg_addr));
    assign adv  = tick && ctrl.run;

    rtc_alarm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wsel  (wsel),
        .wdata (reg_wdata),
        .raddr (rtc_addr_e'(reg_addr)),
        .cnt   (cnt_q),
        .flags (flag_q),
        .alarm (alarm),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    rtc_alarm_cmp #(.CNT_W(CNT_W)) cmp_i (
        .cnt      (cnt_q),
        .alarm    (alarm),
        .mode     (ctrl.mode),
        .adv      (adv),
        .load     (wsel.ld_timer),
        .nxt      (cnt_nxt),
        .evt      (evt),
        .zero_req (zero_req)
    );

    rtc_count_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .load     (wsel.ld_timer),
        .load_val (reg_wdata),
        .zero_req (zero_req),
        .adv      (adv),
        .nxt      (cnt_nxt),
        .cnt      (cnt_q)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_ALARM] = evt.hit;
        flag_set[FLAG_OVF]   = evt.wrapped;
        flag_clr            = wsel.ld_status ? reg_wdata[NUM_FLAGS-1:0] : '0;
    end

    rtc_flag_bank #(.N(NUM_FLAGS)) flags_i (
        .clk (clk),
        .rst (rst),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flag_q)
    );

    assign irq = flag_q[FLAG_ALARM];
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] alm,
    input logic             run,
    input logic             mode,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic wr_timer, wr_status;
    assign wr_timer  = reg_wr && (reg_addr == 2'd0);
    assign wr_status = reg_wr && (reg_addr == 2'd3);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt == '0) && !irq && !run && (alm == '0));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !(tick && run) && !wr_timer |=> $stable(cnt));

    a_r3_wrap_step: assert property (@(posedge clk) disable iff (rst)
        tick && run && !mode && !wr_timer |=> cnt == $past(cnt) + ONE);

    a_r5_periodic_clear: assert property (@(posedge clk) disable iff (rst)
        tick && run && mode && (alm != '0) && (cnt + ONE == alm) && !wr_timer
        |=> (cnt == '0) && irq);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        irq && !(wr_status && reg_wdata[0]) |=> irq);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        wr_timer |=> cnt == $past(reg_wdata));
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .alm       (alarm),
    .run       (ctrl.run),
    .mode      (ctrl.mode),
    .irq       (irq)
);

// File: tb/rtc_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state, kept from the requirements
    logic [31:0] m_cnt = '0, m_alm = '0;
    logic        m_run = 0, m_mode = 0, m_af = 0, m_of = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #0.2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic step(input logic t, input logic w, input logic [1:0] a,
                        input logic [31:0] d, input string req);
        logic [31:0] nx;
        logic aset, oset;
        @(negedge clk);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        aset = 0; oset = 0;
        if (w && a == 2'd0) m_cnt = d;
        else if (t && m_run) begin
            nx = m_cnt + 32'd1;
            if (m_alm != 0 && nx == m_alm) aset = 1;
            if (!m_mode && nx == 0) oset = 1;
            m_cnt = (aset && m_mode) ? 32'd0 : nx;
        end
        if (w && a == 2'd1) m_alm = d;
        if (w && a == 2'd2) begin m_run = d[0]; m_mode = d[1]; end
        m_af = aset | (m_af & ~(w && a == 2'd3 && d[0]));
        m_of = oset | (m_of & ~(w && a == 2'd3 && d[1]));
        #0.5;
        tick = 0; reg_wr = 0;
        rd(2'd0, req, m_cnt);
        rd(2'd3, req, {30'd0, m_of, m_af});
        chk(req, {31'd0, irq}, {31'd0, m_af});
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #0.5;
        // R1 reset state
        rd(2'd0, "R1 timer", 0);
        rd(2'd1, "R1 alarm", 0);
        rd(2'd2, "R1 ctrl", 0);
        rd(2'd3, "R1 status", 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 stopped counter ignores ticks
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R2 stopped");
        step(0, 1, 2'd2, 32'd1, "R2 run on");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R2 no tick");

        // R4 wrap-mode equality alarm with gapped ticks
        step(0, 1, 2'd1, 32'd7, "R4 set alarm");
        for (int i = 0; i < 24; i++) step(i % 3 != 2, 0, 0, 0, "R2 R4 sweep");

        // R7 write 0 no effect, write 1 clears
        step(0, 1, 2'd3, 32'd0, "R7 write zero");
        step(0, 1, 2'd3, 32'd1, "R7 clear");

        // R3 roll with alarm past the roll (R4)
        step(0, 1, 2'd0, 32'hFFFF_FFFA, "R8 load");
        step(0, 1, 2'd1, 32'd3, "R4 alarm past roll");
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, "R3 R4 roll");
        step(0, 1, 2'd3, 32'd3, "R7 clear both");

        // R5 periodic sweep over alarm values
        step(0, 1, 2'd2, 32'd3, "R5 periodic on");
        for (int a = 1; a <= 6; a++) begin
            step(0, 1, 2'd1, 32'(a), "R5 alarm");
            step(0, 1, 2'd0, 0, "R5 zero timer");
            step(0, 1, 2'd3, 32'd1, "R5 clear");
            for (int i = 0; i < 3 * a + 2; i++) step(1, 0, 0, 0, "R5 period");
            rd(2'd1, "R5 alarm kept", 32'(a));
        end

        // R6 alarm zero disabled, periodic then wrap mode
        step(0, 1, 2'd1, 0, "R6 alarm zero");
        step(0, 1, 2'd3, 32'd3, "R6 clear");
        step(0, 1, 2'd0, 32'hFFFF_FFFE, "R6 load");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R6 periodic silent");
        step(0, 1, 2'd2, 32'd1, "R6 wrap mode");
        step(0, 1, 2'd0, 32'hFFFF_FFFF, "R6 load");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R6 wrap no alarm");
        step(0, 1, 2'd3, 32'd3, "R6 clear");

        // R8 load beats tick and periodic clear
        step(0, 1, 2'd2, 32'd3, "R8 periodic");
        step(0, 1, 2'd1, 32'd4, "R8 alarm");
        step(1, 1, 2'd0, 32'd3, "R8 load with tick");
        step(1, 1, 2'd0, 32'd3, "R8 load at A-1");
        step(1, 0, 0, 0, "R8 then alarm");

        // R7 set wins over same-cycle clear
        step(0, 1, 2'd0, 32'd2, "R7 load");
        step(0, 1, 2'd3, 32'd1, "R7 clear");
        step(1, 0, 0, 0, "R7 tick");
        step(1, 1, 2'd3, 32'd1, "R7 set beats clear");

        // R9 unused control bits read zero
        step(0, 1, 2'd2, 32'hFFFF_FFFF, "R9 ctrl write");
        rd(2'd2, "R9 ctrl readback", 32'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule